// File: doc/BRIEF.md
# Burst Frequency and Phase Derotator

This block removes a constant carrier frequency offset and a constant phase offset from a burst of complex baseband samples. Samples are written into one bank of a two-bank burst store while the previously stored burst is read back from the other bank. Each read-back sample is rotated by the negative of an accumulated phase. The accumulated phase starts at the phase estimate and advances once per sample by a step taken from a spectral bin index. The estimator that produces the bin index and the phase is outside this block.

The phase is held as an unsigned fraction of a turn, `PW` bits wide (4096 steps per turn by default). With FFT size N = 2^`NLOG` and modulation order M = 2^`mlog`, the per-sample step equals bin·2^PW/(M·N). Because M and N are powers of two, the step is the sign-extended bin shifted left by PW−NLOG−mlog, with no divider. The top `TW` bits of the phase address a cosine table, and the sine comes from the same table a quarter turn earlier. A registered complex multiplier then rounds and saturates the product back to the sample width.

A three-state controller sequences each burst. **IDLE** waits; the transition *start* (an estimate is pending and the read bank holds a complete burst) moves it to **LOAD**. LOAD copies the pending estimate into the active registers, presets the accumulator and computes the step, then always takes the transition *go* to **RUN**. RUN reads one sample per clock. After the last sample has been read it takes the transition *done* back to IDLE, which frees the bank and moves the read side to the other bank.

Top module: `burst_derotator`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and no output is produced until a burst and its estimate have both been supplied.
- R2: Output sample l (l = 0..L−1) equals r(l)·exp(−j·2π·θ(l)/4096), where θ(l) = (phase + l·step) mod 4096 truncated to a multiple of 16 (top 8 bits), within ±2 LSB per component. Here `est_phase` is that 12-bit turn fraction and step = k·4096/(M·128).
- R3: A 7-bit `est_bin` value of 64 or more is taken as the negative bin value `est_bin`−128.
- R4: `est_mlog` is the base-2 logarithm of M (code 0→M=1, 1→2, 2→4, 3→8), and the step shrinks by half for each increment of the code.
- R5: A rotated component outside the sample range is clipped to +127 or −128 (8-bit samples).
- R6: Each burst of length L = `est_len` (1..64) produces exactly L outputs on consecutive clocks, with `out_last` set on the L-th output only.
- R7: A fully written burst is not corrected until its estimate arrives; no output appears in the meantime.
- R8: A burst can be written into the free bank while the other bank is being corrected, and bursts are output in the order they were written, each one unaltered by the other.
- R9: An estimate presented while a burst is being corrected does not change that burst; it applies to the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write-side sample strobe |
| wr_i | input | DW | Write-side in-phase sample, signed |
| wr_q | input | DW | Write-side quadrature sample, signed |
| wr_last | input | 1 | Marks the final sample of the burst being written |
| est_valid | input | 1 | One-cycle strobe that captures an estimate |
| est_bin | input | NLOG | Spectral bin index, upper half means negative |
| est_phase | input | PW | Initial phase as fraction of a turn |
| est_mlog | input | 2 | log2 of the modulation order |
| est_len | input | AW+1 | Burst length L |
| out_valid | output | 1 | Corrected sample strobe |
| out_i | output | DW | Corrected in-phase sample |
| out_q | output | DW | Corrected quadrature sample |
| out_last | output | 1 | Final corrected sample of the burst |

## Verification
The rotation is tried with a zero bin and zero phase, where the output must equal the input, and then with a positive bin and an arbitrary phase, which exposes errors in the step scaling and in the phase preset. A bin from the upper half is applied to tell signed from unsigned bin handling. Modulation codes 0 and 3 are applied to show that the shift follows `est_mlog`. Full-scale samples rotated onto an axis make the result overflow, which tells saturation from wraparound. A burst left waiting without its estimate, and two overlapping bursts with the second estimate arriving mid-correction, separate correct bank and estimate sequencing from leakage between bursts.

// File: rtl/derot_pkg.sv
package derot_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOAD = 2'd1,
        S_RUN  = 2'd2
    } derot_state_t;

    // Cosine of idx/2^tabw turns scaled by amp, from a Taylor series.
    function automatic int cos_fn(input int idx, input int tabw, input int amp);
        real pi_v;
        real ang;
        real term;
        real sum;
        real scaled;
        pi_v = 3.14159265358979323846;
        ang  = 2.0 * pi_v * real'(idx) / real'(1 << tabw);
        if (ang > pi_v) ang = ang - 2.0 * pi_v;
        term = 1.0;
        sum  = 1.0;
        for (int n = 1; n <= 14; n++) begin
            term = -term * ang * ang / real'((2 * n - 1) * (2 * n));
            sum  = sum + term;
        end
        scaled = sum * real'(amp);
        if (scaled >= 0.0) return $rtoi(scaled + 0.5);
        else return -$rtoi(-scaled + 0.5);
    endfunction

endpackage

// File: rtl/derot_bank_buf.sv
module derot_bank_buf #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_i,
    input  logic [DW-1:0] wr_q,
    input  logic          wr_last,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_release,
    output logic          rd_ready,
    output logic [DW-1:0] rd_i,
    output logic [DW-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;
    localparam int TOTAL = 2 * DEPTH;

    logic [2*DW-1:0] mem [TOTAL];
    logic [AW-1:0]   wr_addr;
    logic            wr_bank;
    logic            rd_bank;
    logic [1:0]      full;

    always_ff @(posedge clk) begin
        if (wr_valid) mem[{wr_bank, wr_addr}] <= {wr_i, wr_q};
        if (rd_en) {rd_i, rd_q} <= mem[{rd_bank, rd_addr}];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_bank <= 1'b0;
            rd_bank <= 1'b0;
            full    <= 2'b00;
        end else begin
            if (wr_valid) begin
                if (wr_last) begin
                    wr_addr        <= '0;
                    wr_bank        <= ~wr_bank;
                    full[wr_bank]  <= 1'b1;
                end else begin
                    wr_addr <= wr_addr + 1'b1;
                end
            end
            if (rd_release) begin
                full[rd_bank] <= 1'b0;
                rd_bank       <= ~rd_bank;
            end
        end
    end

    assign rd_ready = full[rd_bank];

    // R8: the read side only ever touches a bank that the write side has completed
    p_read_full_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> full[rd_bank]);

endmodule

// File: rtl/derot_phase_gen.sv
module derot_phase_gen #(
    parameter int NLOG = 7,
    parameter int PW   = 12,
    parameter int TW   = 8,
    parameter int CW   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [NLOG-1:0]      bin,
    input  logic [1:0]           mlog,
    input  logic [PW-1:0]        phase0,
    output logic signed [CW-1:0] cos_o,
    output logic signed [CW-1:0] sin_o
);
    import derot_pkg::*;

    localparam int TAB = 1 << TW;
    localparam int QTR = TAB / 4;
    localparam int AMP = (1 << (CW - 1)) - 1;
    localparam int SH0 = PW - NLOG;

    logic signed [CW-1:0] cos_tab [TAB];

    for (genvar g = 0; g < TAB; g++) begin : g_tab
        localparam int CV = cos_fn(g, TW, AMP);
        assign cos_tab[g] = CW'(CV);
    end

    logic [PW-1:0]        acc;
    logic [PW-1:0]        inc;
    logic signed [PW-1:0] bin_ext;
    logic [3:0]           sh_amt;
    logic [TW-1:0]        c_idx;
    logic [TW-1:0]        s_idx;

    always_comb begin
        bin_ext = PW'(signed'(bin));
        sh_amt  = 4'(SH0) - {2'b00, mlog};
        c_idx   = acc[PW-1 -: TW];
        s_idx   = c_idx - TW'(QTR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            inc <= '0;
        end else if (load) begin
            acc <= phase0;
            inc <= PW'(bin_ext <<< sh_amt);
        end else if (step) begin
            acc <= acc + inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_o <= '0;
            sin_o <= '0;
        end else begin
            cos_o <= cos_tab[c_idx];
            sin_o <= cos_tab[s_idx];
        end
    end

endmodule

// File: rtl/derot_cmul.sv
module derot_cmul #(
    parameter int DW = 8,
    parameter int CW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 in_last,
    input  logic signed [DW-1:0] ri,
    input  logic signed [DW-1:0] rq,
    input  logic signed [CW-1:0] c,
    input  logic signed [CW-1:0] s,
    output logic                 out_vld,
    output logic                 out_last,
    output logic [DW-1:0]        ui,
    output logic [DW-1:0]        uq
);
    localparam int PRW  = DW + CW;
    localparam int SW   = PRW + 1;
    localparam int RNDI = 1 << (CW - 2);
    localparam int MAXI = (1 << (DW - 1)) - 1;
    localparam int MINI = -(1 << (DW - 1));

    logic signed [PRW-1:0] p_ic, p_qs, p_qc, p_is;
    logic signed [SW-1:0]  sum_i, sum_q, sh_i, sh_q;
    logic signed [DW-1:0]  sat_i, sat_q;

    function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
        if (v > SW'(MAXI)) return DW'(MAXI);
        else if (v < SW'(MINI)) return DW'(MINI);
        else return DW'(v);
    endfunction

    always_comb begin
        p_ic  = ri * c;
        p_qs  = rq * s;
        p_qc  = rq * c;
        p_is  = ri * s;
        sum_i = SW'(p_ic) + SW'(p_qs);
        sum_q = SW'(p_qc) - SW'(p_is);
        sh_i  = (sum_i + SW'(RNDI)) >>> (CW - 1);
        sh_q  = (sum_q + SW'(RNDI)) >>> (CW - 1);
        sat_i = clip(sh_i);
        sat_q = clip(sh_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            ui       <= '0;
            uq       <= '0;
        end else begin
            out_vld  <= in_vld;
            out_last <= in_vld & in_last;
            ui       <= sat_i;
            uq       <= sat_q;
        end
    end

    // R6: an end-of-burst mark never appears without a sample
    p_last_has_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_vld);

endmodule

// File: rtl/burst_derotator.sv
module burst_derotator #(
    parameter int DW   = 8,
    parameter int AW   = 6,
    parameter int NLOG = 7,
    parameter int PW   = 12,
    parameter int TW   = 8,
    parameter int CW   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [DW-1:0]   wr_i,
    input  logic [DW-1:0]   wr_q,
    input  logic            wr_last,
    input  logic            est_valid,
    input  logic [NLOG-1:0] est_bin,
    input  logic [PW-1:0]   est_phase,
    input  logic [1:0]      est_mlog,
    input  logic [AW:0]     est_len,
    output logic            out_valid,
    output logic [DW-1:0]   out_i,
    output logic [DW-1:0]   out_q,
    output logic            out_last
);
    import derot_pkg::*;

    localparam int LW = AW + 1;

    derot_state_t state, nxt;

    logic            est_pend;
    logic [NLOG-1:0] pend_bin;
    logic [PW-1:0]   pend_phase;
    logic [1:0]      pend_mlog;
    logic [LW-1:0]   pend_len;
    logic [LW-1:0]   act_len;
    logic [AW-1:0]   cnt;

    logic load, run, run_last, release_bank, bank_ready;
    logic s1_vld, s1_last;
    logic [DW-1:0] buf_i, buf_q;
    logic signed [CW-1:0] cos_v, sin_v;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions: start, go, done
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (est_pend && bank_ready) nxt = S_LOAD;
            S_LOAD: nxt = S_RUN;
            S_RUN:  if (run_last) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state-derived controls
    always_comb begin
        run_last     = ({1'b0, cnt} == act_len - 1'b1);
        load         = (state == S_LOAD);
        run          = (state == S_RUN);
        release_bank = run && run_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est_pend   <= 1'b0;
            pend_bin   <= '0;
            pend_phase <= '0;
            pend_mlog  <= '0;
            pend_len   <= '0;
            act_len    <= '0;
            cnt        <= '0;
            s1_vld     <= 1'b0;
            s1_last    <= 1'b0;
        end else begin
            if (est_valid) begin
                est_pend   <= 1'b1;
                pend_bin   <= est_bin;
                pend_phase <= est_phase;
                pend_mlog  <= est_mlog;
                pend_len   <= est_len;
            end else if (load) begin
                est_pend <= 1'b0;
            end
            if (load) begin
                act_len <= pend_len;
                cnt     <= '0;
            end else if (run) begin
                cnt <= cnt + 1'b1;
            end
            s1_vld  <= run;
            s1_last <= release_bank;
        end
    end

    derot_bank_buf #(.DW(DW), .AW(AW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_i       (wr_i),
        .wr_q       (wr_q),
        .wr_last    (wr_last),
        .rd_en      (run),
        .rd_addr    (cnt),
        .rd_release (release_bank),
        .rd_ready   (bank_ready),
        .rd_i       (buf_i),
        .rd_q       (buf_q)
    );

    derot_phase_gen #(.NLOG(NLOG), .PW(PW), .TW(TW), .CW(CW)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (run),
        .bin    (pend_bin),
        .mlog   (pend_mlog),
        .phase0 (pend_phase),
        .cos_o  (cos_v),
        .sin_o  (sin_v)
    );

    derot_cmul #(.DW(DW), .CW(CW)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (s1_vld),
        .in_last  (s1_last),
        .ri       (signed'(buf_i)),
        .rq       (signed'(buf_q)),
        .c        (cos_v),
        .s        (sin_v),
        .out_vld  (out_valid),
        .out_last (out_last),
        .ui       (out_i),
        .uq       (out_q)
    );

    // R6: a stream of corrected samples only stops right after its last sample
    p_stream_ends_at_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_last));

    // R7: correction of a burst is only prepared once an estimate was pending
    p_load_needs_estimate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD) |-> $past(est_pend));

endmodule

// File: tb/burst_derotator_bench.sv
module burst_derotator_bench;
    localparam int DW = 8;
    localparam int AW = 6;
    localparam int NLOG = 7;
    localparam int PW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [DW-1:0] wr_i = '0;
    logic [DW-1:0] wr_q = '0;
    logic wr_last = 1'b0;
    logic est_valid = 1'b0;
    logic [NLOG-1:0] est_bin = '0;
    logic [PW-1:0] est_phase = '0;
    logic [1:0] est_mlog = '0;
    logic [AW:0] est_len = '0;
    logic out_valid;
    logic [DW-1:0] out_i, out_q;
    logic out_last;

    int checks = 0;
    int fails = 0;
    int ocnt = 0;
    int got_i [256];
    int got_q [256];
    bit got_last [256];

    always #2 clk = ~clk;

    burst_derotator u_burst_derotator (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_i(wr_i), .wr_q(wr_q),
        .wr_last(wr_last), .est_valid(est_valid), .est_bin(est_bin),
        .est_phase(est_phase), .est_mlog(est_mlog), .est_len(est_len),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_last(out_last)
    );

    always @(negedge clk) begin
        if (out_valid && ocnt < 256) begin
            got_i[ocnt]    = int'(signed'(out_i));
            got_q[ocnt]    = int'(signed'(out_q));
            got_last[ocnt] = out_last;
            ocnt = ocnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int smp(input int l, input int seed, input bit q);
        if (seed == 99) return 127;
        if (seed == 98) return -128;
        if (q) return ((l * 59 + seed * 29 + 17) % 161) - 80;
        return ((l * 37 + seed * 53) % 161) - 80;
    endfunction

    function automatic int model(input int ri, input int rq, input int l, input int bin,
                                 input int phase, input int mlog, input bit q);
        int kk, inc, th, idx, r;
        real a, v;
        kk  = (bin >= 64) ? bin - 128 : bin;
        inc = kk * (32 >> mlog);
        th  = phase + l * inc;
        th  = ((th % 4096) + 4096) % 4096;
        idx = th / 16;
        a   = 2.0 * 3.14159265358979 * real'(idx) / 256.0;
        if (q) v = real'(rq) * $cos(a) - real'(ri) * $sin(a);
        else   v = real'(ri) * $cos(a) + real'(rq) * $sin(a);
        r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
        if (r > 127) r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    task automatic write_burst(input int len, input int seed);
        for (int l = 0; l < len; l++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_i = DW'(smp(l, seed, 1'b0));
            wr_q = DW'(smp(l, seed, 1'b1));
            wr_last = (l == len - 1);
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last = 1'b0;
    endtask

    task automatic give_est(input int bin, input int phase, input int mlog, input int len);
        @(negedge clk);
        est_valid = 1'b1;
        est_bin = NLOG'(bin);
        est_phase = PW'(phase);
        est_mlog = 2'(mlog);
        est_len = (AW + 1)'(len);
        @(negedge clk);
        est_valid = 1'b0;
        est_bin = '0;
        est_phase = '0;
    endtask

    task automatic wait_out(input int n);
        for (int t = 0; t < 400 && ocnt < n; t++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic check_burst(input int base, input int len, input int seed, input int bin,
                               input int phase, input int mlog, input string tag);
        for (int l = 0; l < len; l++) begin
            int ei, eq, ri, rq;
            ri = smp(l, seed, 1'b0);
            rq = smp(l, seed, 1'b1);
            ei = model(ri, rq, l, bin, phase, mlog, 1'b0);
            eq = model(ri, rq, l, bin, phase, mlog, 1'b1);
            chk((got_i[base + l] - ei) <= 2 && (ei - got_i[base + l]) <= 2,
                {tag, " I"}, got_i[base + l], ei);
            chk((got_q[base + l] - eq) <= 2 && (eq - got_q[base + l]) <= 2,
                {tag, " Q"}, got_q[base + l], eq);
            chk(got_last[base + l] == (l == len - 1), "R6 last flag position",
                int'(got_last[base + l]), int'(l == len - 1));
        end
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(out_last == 1'b0, "R1 out_last after reset", int'(out_last), 0);
        repeat (10) @(negedge clk);
        chk(ocnt == 0, "R1 no output while idle", ocnt, 0);
    endtask

    task automatic t_identity;
        ocnt = 0;
        write_burst(8, 1);
        give_est(0, 0, 2, 8);
        wait_out(8);
        chk(ocnt == 8, "R6 output count identity", ocnt, 8);
        check_burst(0, 8, 1, 0, 0, 2, "R2 identity");
    endtask

    task automatic t_rotate;
        ocnt = 0;
        write_burst(16, 2);
        give_est(5, 300, 2, 16);
        wait_out(16);
        chk(ocnt == 16, "R6 output count rotate", ocnt, 16);
        check_burst(0, 16, 2, 5, 300, 2, "R2 positive bin");
    endtask

    task automatic t_negative;
        ocnt = 0;
        write_burst(20, 3);
        give_est(125, 1000, 2, 20);
        wait_out(20);
        chk(ocnt == 20, "R6 output count negative", ocnt, 20);
        check_burst(0, 20, 3, 125, 1000, 2, "R3 negative bin");
    endtask

    task automatic t_mod_orders;
        ocnt = 0;
        write_burst(12, 4);
        give_est(7, 50, 0, 12);
        wait_out(12);
        check_burst(0, 12, 4, 7, 50, 0, "R4 M=1");
        ocnt = 0;
        write_burst(12, 4);
        give_est(7, 50, 3, 12);
        wait_out(12);
        check_burst(0, 12, 4, 7, 50, 3, "R4 M=8");
    endtask

    task automatic t_saturate;
        ocnt = 0;
        write_burst(4, 99);
        give_est(0, 512, 1, 4);
        wait_out(4);
        chk(got_i[0] == 127, "R5 positive clip", got_i[0], 127);
        check_burst(0, 4, 99, 0, 512, 1, "R5 positive burst");
        ocnt = 0;
        write_burst(4, 98);
        give_est(0, 512, 1, 4);
        wait_out(4);
        chk(got_i[3] == -128, "R5 negative clip", got_i[3], -128);
        check_burst(0, 4, 98, 0, 512, 1, "R5 negative burst");
    endtask

    task automatic t_gating;
        ocnt = 0;
        write_burst(10, 5);
        repeat (30) @(negedge clk);
        chk(ocnt == 0, "R7 no output without estimate", ocnt, 0);
        give_est(9, 2000, 2, 10);
        wait_out(10);
        chk(ocnt == 10, "R7 output after estimate", ocnt, 10);
        check_burst(0, 10, 5, 9, 2000, 2, "R7 delayed estimate");
    endtask

    task automatic t_pingpong;
        ocnt = 0;
        give_est(3, 100, 2, 20);
        write_burst(20, 6);
        give_est(120, 3500, 1, 24);
        write_burst(24, 7);
        wait_out(44);
        chk(ocnt == 44, "R8 total outputs two bursts", ocnt, 44);
        check_burst(0, 20, 6, 3, 100, 2, "R9 first burst keeps its estimate");
        check_burst(20, 24, 7, 120, 3500, 1, "R8 second burst");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_rotate();
        t_negative();
        t_mod_orders();
        t_saturate();
        t_gating();
        t_pingpong();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", ocnt, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule